// File: doc/BRIEF.md
# ASCII Command to Register Bridge

This block sits between a UART receiver, a UART transmitter and an internal 16-bit register bus. It takes already-decoded characters one at a time, recognises short text commands that write or read a register, and runs one single-beat bus cycle for each well-formed command. The outcome is sent back as a few ASCII characters, ready for a serialiser to transmit.

A write is typed as `W`, a space, four hex digits of address, a space, four hex digits of data and a closing space. A read is `R`, a space, four hex digits of address and a closing space. The closing space starts the bus cycle; no line terminator is needed. Right after reset the block announces itself with a banner. Characters that reach it while it is busy are discarded, and the parser picks up again at the next command letter.

Top module: `cmd_reg_bridge`

## Requirements
- R1: After reset the reply stream sends the seven bytes 0x52 0x45 0x41 0x44 0x59 0x0D 0x0A ("READY", CR, LF); input characters received before the banner has fully drained are discarded.
- R2: The 12-character sequence `W` (0x57), space (0x20), four hex address digits, space, four hex data digits, space produces exactly one bus cycle with bus_we=1, the address and data taken most significant digit first, and the reply "OK" CR LF.
- R3: The 7-character sequence `R` (0x52), space, four hex address digits, space produces exactly one bus cycle with bus_we=0, and the reply is the four digits of bus_rdat in uppercase hex, most significant first, followed by CR LF.
- R4: Hex digits 0-9, A-F and a-f are all accepted; a lowercase digit decodes to the same value as its uppercase form.
- R5: Inside a command, a character that is not the expected space or hex digit (a non-hex character, a missing space, too few or too many digits) abandons the command with no bus cycle and the reply "?" CR LF.
- R6: While no command is open, every character other than `W` and `R` is ignored: no reply and no bus cycle.
- R7: bus_cyc and bus_stb rise together and stay high with bus_we, bus_adr and bus_wdat unchanged until bus_ack is sampled high; they fall on the clock after that (single beat).
- R8: If bus_ack has not been seen after TIMEOUT (default 256) clocks of bus_cyc high, the cycle is dropped and the reply is "TO" CR LF.
- R9: A reply byte moves on a clock where tx_valid and tx_ready are both high; while tx_ready is low, tx_valid stays high and tx_data holds.
- R10: Characters that arrive while a reply is draining or a bus cycle is outstanding are discarded and have no effect on the bus or the registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-clock strobe: rx_data holds a received character |
| rx_data | input | 8 | Received ASCII character |
| tx_valid | output | 1 | Reply byte available |
| tx_data | output | 8 | Reply ASCII byte |
| tx_ready | input | 1 | Transmitter takes tx_data this clock |
| bus_cyc | output | 1 | Bus cycle in progress |
| bus_stb | output | 1 | Bus strobe, high with bus_cyc |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_adr | output | ADDR_W | Register address |
| bus_wdat | output | DATA_W | Write data |
| bus_rdat | input | DATA_W | Read data, valid with bus_ack |
| bus_ack | input | 1 | Slave acknowledge |

## Verification
The bus-side contract is watched on every clock: request fields held steady until acknowledge, the cycle ending right after acknowledge, the cycle never outliving the timeout window, a reply byte frozen while the transmitter stalls, and no bus cycle ever starting while a reply is still pending. What the assertions cannot show is whether the text was understood correctly: the decoded address and data, the exact reply characters, lowercase digits, the rejection of malformed commands, silent discarding of stray or late characters, and the banner. Those come only from the bench's command scenarios, which compare the captured reply text and the recorded bus transactions against values worked out from the command strings.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [2:0] {
        RPL_BANNER,
        RPL_READ,
        RPL_OK,
        RPL_BAD,
        RPL_TIMEOUT
    } reply_kind_e;

    localparam logic [7:0] CH_SP = 8'h20;
    localparam logic [7:0] CH_CR = 8'h0D;
    localparam logic [7:0] CH_LF = 8'h0A;
    localparam logic [7:0] CH_WR = 8'h57;
    localparam logic [7:0] CH_RD = 8'h52;

    // Returns {is_hex, nibble}
    function automatic logic [4:0] hex_decode(input logic [7:0] c);
        logic [7:0] t;
        t = 8'h00;
        if (c >= 8'h30 && c <= 8'h39) begin
            t = c - 8'h30;
            return {1'b1, t[3:0]};
        end else if (c >= 8'h41 && c <= 8'h46) begin
            t = c - 8'h37;
            return {1'b1, t[3:0]};
        end else if (c >= 8'h61 && c <= 8'h66) begin
            t = c - 8'h57;
            return {1'b1, t[3:0]};
        end
        return 5'b0_0000;
    endfunction

    function automatic logic [7:0] hex_encode(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction

endpackage

// File: rtl/crb_parser.sv
module crb_parser
    import crb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              accept_en,
    input  logic              done,
    output logic              req_o,
    output logic              bad_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] adr_o,
    output logic [DATA_W-1:0] wdat_o
);

    localparam int ADIG = ADDR_W / 4;
    localparam int DDIG = DATA_W / 4;
    localparam int MDIG = (ADIG > DDIG) ? ADIG : DDIG;
    localparam int CW   = $clog2(MDIG + 1);
    localparam logic [CW-1:0] A_LAST = CW'(ADIG - 1);
    localparam logic [CW-1:0] D_LAST = CW'(DDIG - 1);

    typedef enum logic [2:0] {
        PS_IDLE, PS_SEP1, PS_ADDR, PS_SEP2, PS_DATA, PS_SEP3, PS_WAIT
    } pstate_e;

    typedef struct packed {
        pstate_e             st;
        logic                we;
        logic [ADDR_W-1:0]   adr;
        logic [DATA_W-1:0]   wdat;
        logic [CW-1:0]       cnt;
        logic                req;
        logic                bad;
    } pars_t;

    pars_t q, d;
    logic       dig_ok;
    logic [3:0] nib;
    logic       take;
    logic       fail;

    always_comb begin
        d       = q;
        d.req   = 1'b0;
        d.bad   = 1'b0;
        fail    = 1'b0;
        {dig_ok, nib} = hex_decode(rx_data);
        take    = rx_valid && accept_en && (q.st != PS_WAIT);

        if (q.st == PS_WAIT) begin
            if (done) d.st = PS_IDLE;
        end else if (take) begin
            case (q.st)
                PS_IDLE: begin
                    if (rx_data == CH_WR) begin
                        d.we = 1'b1;
                        d.st = PS_SEP1;
                    end else if (rx_data == CH_RD) begin
                        d.we = 1'b0;
                        d.st = PS_SEP1;
                    end
                end
                PS_SEP1: begin
                    if (rx_data == CH_SP) begin
                        d.st  = PS_ADDR;
                        d.cnt = '0;
                        d.adr = '0;
                    end else fail = 1'b1;
                end
                PS_ADDR: begin
                    if (dig_ok) begin
                        d.adr = {q.adr[ADDR_W-5:0], nib};
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == A_LAST) d.st = PS_SEP2;
                    end else fail = 1'b1;
                end
                PS_SEP2: begin
                    if (rx_data != CH_SP) begin
                        fail = 1'b1;
                    end else if (q.we) begin
                        d.st   = PS_DATA;
                        d.cnt  = '0;
                        d.wdat = '0;
                    end else begin
                        d.st  = PS_WAIT;
                        d.req = 1'b1;
                    end
                end
                PS_DATA: begin
                    if (dig_ok) begin
                        d.wdat = {q.wdat[DATA_W-5:0], nib};
                        d.cnt  = q.cnt + 1'b1;
                        if (q.cnt == D_LAST) d.st = PS_SEP3;
                    end else fail = 1'b1;
                end
                PS_SEP3: begin
                    if (rx_data == CH_SP) begin
                        d.st  = PS_WAIT;
                        d.req = 1'b1;
                    end else fail = 1'b1;
                end
                default: d.st = PS_IDLE;
            endcase
            if (fail) begin
                d.st  = PS_IDLE;
                d.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= PS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_o  = q.req;
    assign bad_o  = q.bad;
    assign we_o   = q.we;
    assign adr_o  = q.adr;
    assign wdat_o = q.wdat;

endmodule

// File: rtl/crb_bus_master.sv
module crb_bus_master #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] adr,
    input  logic [DATA_W-1:0] wdat,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdat,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_wdat,
    output logic              done,
    output logic              timed_out,
    output logic [DATA_W-1:0] rdata
);

    localparam int TW = $clog2(TIMEOUT);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT - 1);

    typedef struct packed {
        logic              act;
        logic              we;
        logic [ADDR_W-1:0] adr;
        logic [DATA_W-1:0] wdat;
        logic [TW-1:0]     cnt;
        logic              done;
        logic              tmo;
        logic [DATA_W-1:0] rdata;
    } bus_t;

    bus_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.act) begin
            if (req) begin
                d.act  = 1'b1;
                d.we   = we;
                d.adr  = adr;
                d.wdat = wdat;
                d.cnt  = '0;
            end
        end else if (bus_ack) begin
            d.act   = 1'b0;
            d.done  = 1'b1;
            d.tmo   = 1'b0;
            d.rdata = bus_rdat;
        end else if (q.cnt == T_LAST) begin
            d.act  = 1'b0;
            d.done = 1'b1;
            d.tmo  = 1'b1;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_cyc   = q.act;
    assign bus_stb   = q.act;
    assign bus_we    = q.we;
    assign bus_adr   = q.adr;
    assign bus_wdat  = q.wdat;
    assign done      = q.done;
    assign timed_out = q.tmo;
    assign rdata     = q.rdata;

endmodule

// File: rtl/crb_reply.sv
module crb_reply
    import crb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  reply_kind_e       kind,
    input  logic [DATA_W-1:0] data,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data
);

    localparam int NDIG  = DATA_W / 4;
    localparam int DEPTH = (NDIG + 2 > 7) ? NDIG + 2 : 7;
    localparam int IW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                  busy;
        logic [DEPTH-1:0][7:0] text;
        logic [IW-1:0]         len;
        logic [IW-1:0]         idx;
    } rpl_t;

    rpl_t q, d;

    function automatic rpl_t compose(input reply_kind_e k, input logic [DATA_W-1:0] v);
        rpl_t t;
        t      = '0;
        t.busy = 1'b1;
        case (k)
            RPL_BANNER: begin
                t.text[0] = 8'h52;
                t.text[1] = 8'h45;
                t.text[2] = 8'h41;
                t.text[3] = 8'h44;
                t.text[4] = 8'h59;
                t.text[5] = CH_CR;
                t.text[6] = CH_LF;
                t.len     = IW'(7);
            end
            RPL_READ: begin
                for (int i = 0; i < NDIG; i++)
                    t.text[i] = hex_encode(v[DATA_W-1-4*i -: 4]);
                t.text[NDIG]   = CH_CR;
                t.text[NDIG+1] = CH_LF;
                t.len          = IW'(NDIG + 2);
            end
            RPL_OK: begin
                t.text[0] = 8'h4F;
                t.text[1] = 8'h4B;
                t.text[2] = CH_CR;
                t.text[3] = CH_LF;
                t.len     = IW'(4);
            end
            RPL_TIMEOUT: begin
                t.text[0] = 8'h54;
                t.text[1] = 8'h4F;
                t.text[2] = CH_CR;
                t.text[3] = CH_LF;
                t.len     = IW'(4);
            end
            default: begin
                t.text[0] = 8'h3F;
                t.text[1] = CH_CR;
                t.text[2] = CH_LF;
                t.len     = IW'(3);
            end
        endcase
        return t;
    endfunction

    always_comb begin
        d = q;
        if (q.busy) begin
            if (tx_ready) begin
                if (q.idx == q.len - 1'b1) d.busy = 1'b0;
                else                       d.idx  = q.idx + 1'b1;
            end
        end else if (load) begin
            d = compose(kind, data);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= compose(RPL_BANNER, '0);
        else        q <= d;
    end

    assign tx_valid = q.busy;
    assign tx_data  = q.text[q.idx];

endmodule

// File: rtl/cmd_reg_bridge.sv
module cmd_reg_bridge
    import crb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    input  logic              tx_ready,
    output logic              bus_cyc,
    output logic              bus_stb,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_adr,
    output logic [DATA_W-1:0] bus_wdat,
    input  logic [DATA_W-1:0] bus_rdat,
    input  logic              bus_ack
);

    logic              p_req, p_bad, p_we;
    logic [ADDR_W-1:0] p_adr;
    logic [DATA_W-1:0] p_wdat;
    logic              m_done, m_tmo;
    logic [DATA_W-1:0] m_rdata;
    logic              r_load;
    reply_kind_e       r_kind;

    crb_parser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .accept_en (!tx_valid),
        .done      (m_done),
        .req_o     (p_req),
        .bad_o     (p_bad),
        .we_o      (p_we),
        .adr_o     (p_adr),
        .wdat_o    (p_wdat)
    );

    crb_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)) u_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (p_req),
        .we        (p_we),
        .adr       (p_adr),
        .wdat      (p_wdat),
        .bus_ack   (bus_ack),
        .bus_rdat  (bus_rdat),
        .bus_cyc   (bus_cyc),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_adr   (bus_adr),
        .bus_wdat  (bus_wdat),
        .done      (m_done),
        .timed_out (m_tmo),
        .rdata     (m_rdata)
    );

    always_comb begin
        r_load = p_bad || m_done;
        if (p_bad)       r_kind = RPL_BAD;
        else if (m_tmo)  r_kind = RPL_TIMEOUT;
        else if (bus_we) r_kind = RPL_OK;
        else             r_kind = RPL_READ;
    end

    crb_reply #(.DATA_W(DATA_W)) u_reply (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (r_load),
        .kind     (r_kind),
        .data     (m_rdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_data  (tx_data)
    );

endmodule

// File: rtl/cmd_reg_bridge_chk.sv
module cmd_reg_bridge_chk #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int TIMEOUT = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_ready,
    input logic              bus_cyc,
    input logic              bus_stb,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_adr,
    input logic [DATA_W-1:0] bus_wdat,
    input logic              bus_ack
);

    localparam int RW = $clog2(TIMEOUT) + 2;
    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (bus_cyc) run_q <= run_q + 1'b1;
        else              run_q <= '0;
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && $past(bus_cyc) && !$past(bus_ack) |-> bus_stb && $stable(bus_adr) && $stable(bus_we) && $stable(bus_wdat)); // R7

    AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc && bus_ack |=> !bus_cyc && !bus_stb); // R7

    AST_CYC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(TIMEOUT)); // R8

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R9

    AST_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> !tx_valid); // R10

endmodule

bind cmd_reg_bridge cmd_reg_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMEOUT(TIMEOUT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .bus_cyc  (bus_cyc),
    .bus_stb  (bus_stb),
    .bus_we   (bus_we),
    .bus_adr  (bus_adr),
    .bus_wdat (bus_wdat),
    .bus_ack  (bus_ack)
);

// File: tb/cmd_reg_bridge_tb.sv
`timescale 1ns/1ps
module cmd_reg_bridge_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = 8'h00;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b0;
    logic        bus_cyc, bus_stb, bus_we;
    logic [15:0] bus_adr, bus_wdat;
    logic [15:0] bus_rdat = 16'h0000;
    logic        bus_ack = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cmd_reg_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .bus_cyc(bus_cyc), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_adr(bus_adr), .bus_wdat(bus_wdat), .bus_rdat(bus_rdat), .bus_ack(bus_ack)
    );

    localparam logic [15:0] CRLF = 16'h0D0A;

    typedef struct packed {
        logic [95:0] cmd;
        logic [7:0]  clen;
        logic [15:0] ackd;
        logic        stall;
        logic [47:0] rpl;
        logic [7:0]  rlen;
        logic [7:0]  ncyc;
        logic        we;
        logic [15:0] adr;
        logic [15:0] wdat;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{"W 0003 BEEF ",             8'd12, 16'd2,    1'b0, {16'h0, "OK", CRLF},  8'd4, 8'd1, 1'b1, 16'h0003, 16'hBEEF}, // R2
        '{{40'h0, "R 0003 "},         8'd7,  16'd0,    1'b1, {"BEEF", CRLF},       8'd6, 8'd1, 1'b0, 16'h0003, 16'h0000}, // R3
        '{"W 00A5 abcd ",             8'd12, 16'd1,    1'b0, {16'h0, "OK", CRLF},  8'd4, 8'd1, 1'b1, 16'h00A5, 16'hABCD}, // R4
        '{{40'h0, "R 00a5 "},         8'd7,  16'd3,    1'b0, {"ABCD", CRLF},       8'd6, 8'd1, 1'b0, 16'h00A5, 16'h0000}, // R4
        '{"W 0004 12G4 ",             8'd12, 16'd0,    1'b0, {24'h0, "?", CRLF},   8'd3, 8'd0, 1'b0, 16'h0000, 16'h0000}, // R5
        '{{48'h0, "R 012 "},          8'd6,  16'd0,    1'b0, {24'h0, "?", CRLF},   8'd3, 8'd0, 1'b0, 16'h0000, 16'h0000}, // R5
        '{"W 0001 12345",             8'd12, 16'd0,    1'b0, {24'h0, "?", CRLF},   8'd3, 8'd0, 1'b0, 16'h0000, 16'h0000}, // R5
        '{{48'h0, "X Z 1 "},          8'd6,  16'd0,    1'b0, 48'h0,                8'd0, 8'd0, 1'b0, 16'h0000, 16'h0000}, // R6
        '{{40'h0, "R 0009 "},         8'd7,  16'd1000, 1'b0, {16'h0, "TO", CRLF},  8'd4, 8'd1, 1'b0, 16'h0009, 16'h0000}, // R8
        '{{40'h0, "R 0003 "},         8'd7,  16'd200,  1'b1, {"BEEF", CRLF},       8'd6, 8'd1, 1'b0, 16'h0003, 16'h0000}, // R7
        '{"W FFFF 0000 ",             8'd12, 16'd0,    1'b1, {16'h0, "OK", CRLF},  8'd4, 8'd1, 1'b1, 16'hFFFF, 16'h0000}, // R2
        '{{40'h0, "R 000F "},         8'd7,  16'd0,    1'b0, {"0000", CRLF},       8'd6, 8'd1, 1'b0, 16'h000F, 16'h0000}  // R3
    };

    // Bench-side state: reply capture, bus slave model, ready control
    logic [63:0] rbuf = '0;
    int          rlen = 0;
    int          ncyc = 0;
    logic        last_we = 1'b0;
    logic [15:0] last_adr = '0, last_wdat = '0;
    logic [15:0] mem [16];
    int          ack_delay = 0;
    int          wait_cnt = 0;
    logic        cyc_prev = 1'b0;
    logic        hold_ready = 1'b0;
    logic        stall_mode = 1'b0;
    int          tick = 0;

    initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

    always @(negedge clk) begin
        tick = tick + 1;
        // transmitter sink
        tx_ready = hold_ready ? 1'b0 : (stall_mode ? tick[0] : 1'b1);
        if (rst_n && tx_valid && tx_ready) begin
            rbuf = {rbuf[55:0], tx_data};
            rlen = rlen + 1;
        end
        // bus slave
        if (rst_n && bus_cyc && !bus_ack) begin
            if (!cyc_prev) begin
                ncyc      = ncyc + 1;
                last_we   = bus_we;
                last_adr  = bus_adr;
                last_wdat = bus_wdat;
                wait_cnt  = 0;
            end
            if (wait_cnt == ack_delay) begin
                if (bus_we) mem[bus_adr[3:0]] = bus_wdat;
                bus_rdat = mem[bus_adr[3:0]];
                bus_ack  = 1'b1;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end else begin
            bus_ack = 1'b0;
        end
        cyc_prev = bus_cyc;
    end

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic send_str(input logic [95:0] s, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_data  = s[8*(n-1-k) +: 8];
            @(negedge clk);
            rx_valid = 1'b0;
        end
    endtask

    task automatic clear_capture();
        @(negedge clk);
        rbuf = '0;
        rlen = 0;
        ncyc = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..R10 actual=hung expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] held;
        // ---- reset state and banner (R1, R10)
        hold_ready = 1'b1;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "reset tx_valid", {63'h0, tx_valid}, 64'h1);
        check("R1", "reset first byte", {56'h0, tx_data}, 64'h52);
        check("R1", "reset bus_cyc", {63'h0, bus_cyc}, 64'h0);
        send_str("W 0001 0001 ", 12);   // arrives while banner blocked: dropped
        hold_ready = 1'b0;
        idle(40);
        check("R1", "banner text", rbuf, {8'h0, "READY", CRLF});
        check("R1", "banner length", 64'(rlen), 64'd7);
        check("R10", "no bus cycle from input during banner", 64'(ncyc), 64'd0);

        // ---- table of commands
        for (int i = 0; i < NV; i++) begin
            clear_capture();
            ack_delay  = int'(VECS[i].ackd);
            stall_mode = VECS[i].stall;
            send_str(VECS[i].cmd, int'(VECS[i].clen));
            idle(330);
            check("R2/R3/R5/R6/R8", $sformatf("vec %0d reply", i), rbuf, {16'h0, VECS[i].rpl});
            check("R9", $sformatf("vec %0d reply length", i), 64'(rlen), 64'(VECS[i].rlen));
            check("R5/R6", $sformatf("vec %0d bus cycles", i), 64'(ncyc), 64'(VECS[i].ncyc));
            if (VECS[i].ncyc != 0) begin
                check("R2/R3", $sformatf("vec %0d we", i), {63'h0, last_we}, {63'h0, VECS[i].we});
                check("R4", $sformatf("vec %0d address", i), {48'h0, last_adr}, {48'h0, VECS[i].adr});
                if (VECS[i].we)
                    check("R4", $sformatf("vec %0d write data", i), {48'h0, last_wdat}, {48'h0, VECS[i].wdat});
            end
        end
        stall_mode = 1'b0;
        ack_delay  = 0;

        // ---- characters during a draining reply are dropped (R9, R10)
        clear_capture();
        hold_ready = 1'b1;
        send_str("W 0008 2222 ", 12);
        idle(10);
        held = tx_data;
        send_str("W 0009 3333 ", 12);
        check("R9", "tx_valid held while stalled", {63'h0, tx_valid}, 64'h1);
        check("R9", "tx_data held while stalled", {56'h0, tx_data}, {56'h0, held});
        hold_ready = 1'b0;
        idle(40);
        check("R10", "only first command answered", rbuf, {32'h0, "OK", CRLF});
        check("R10", "only first command on bus", 64'(ncyc), 64'd1);
        check("R2", "first command address", {48'h0, last_adr}, 64'h0008);

        clear_capture();
        send_str({40'h0, "R 0009 "}, 7);
        idle(40);
        check("R10", "dropped write left register unchanged", rbuf, {16'h0, "0000", CRLF});

        clear_capture();
        send_str({40'h0, "R 0008 "}, 7);
        idle(40);
        check("R3", "accepted write read back", rbuf, {16'h0, "2222", CRLF});

        // ---- resync after abort: bad command then good one back to back (R5, R6)
        clear_capture();
        send_str({72'h0, "R Q"}, 3);
        idle(20);
        check("R5", "abort reply", rbuf, {40'h0, "?", CRLF});
        clear_capture();
        send_str("W 0002 0A0B ", 12);
        idle(40);
        check("R2", "command after abort", rbuf, {32'h0, "OK", CRLF});
        check("R2", "command after abort data", {48'h0, last_wdat}, 64'h0A0B);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule